// File: doc/BRIEF.md
# Receive Tag Window Table with Completion Counters

This block sits at the receive side of a network-on-chip interface. It keeps a table of receive tags, each of which owns a write window in local memory. The window has a base address, a size in words, and a running offset. A payload flit that names a tag is written to memory at that tag's base plus its current offset, and the offset then advances by one. If the window is already full, the flit is dropped and the tag's sticky overflow flag is set.

An end-of-transfer flit does not write memory. It adds one to the tag's 16-bit completion counter, which holds at its maximum value rather than wrapping. Software has three register operations. It can configure a tag's window, peek at a tag, or read a counter and clear it in the same cycle, so that no completion is lost. A single output is high while any counter in the table is non-zero, which is enough to raise a hardware event.

Top module: `noc_rx_tag_window`

## Requirements
- R1: After reset every window has size 0, offset 0 and overflow clear, every counter is 0, and `mem_we`, `rd_valid` and `any_pending` are low.
- R2: A payload flit (`flit_cmd` = 0) whose tag has offset < size writes `flit_data` at address (base + offset) modulo 2^ADDR_W. The write appears on `mem_we`/`mem_addr`/`mem_wdata` in the cycle after the flit is accepted, and the offset grows by 1. One flit is accepted per cycle.
- R3: A payload flit whose tag has offset >= size produces no memory write and sets that tag's overflow flag. The flag stays set until that tag is configured again.
- R4: A configure operation (`reg_op` = 1) loads base and size, sets the offset to 0, clears overflow, and leaves the counter unchanged. When a flit hits the same tag in the same cycle, the configuration decides the window state that follows.
- R5: An end-of-transfer flit (`flit_cmd` = 1) adds 1 to its tag's counter. Command codes 2 and 3 change nothing.
- R6: A load-and-clear operation (`reg_op` = 3) returns the tag's counter value on `rd_count` in the next cycle and sets the counter to 0. If an end-of-transfer for the same tag arrives in the same cycle, the old value is returned and the counter becomes 1.
- R7: A counter at 65535 stays at 65535 on further end-of-transfer flits.
- R8: `any_pending` is high exactly when at least one counter is non-zero.
- R9: A peek operation (`reg_op` = 2) returns the tag's counter, offset and overflow flag in the next cycle with `rd_valid` high, and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flit_valid | input | 1 | Flit present this cycle |
| flit_tag | input | TAG_W | Receive tag addressed by the flit |
| flit_cmd | input | 2 | 0 payload, 1 end-of-transfer, 2/3 no effect |
| flit_data | input | FLIT_W | Payload word |
| reg_op | input | 2 | 0 idle, 1 configure, 2 peek, 3 load-and-clear |
| reg_tag | input | TAG_W | Tag addressed by the register operation |
| reg_base | input | ADDR_W | Window base for configure |
| reg_size | input | ADDR_W | Window size in words for configure |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | FLIT_W | Memory write data |
| rd_valid | output | 1 | Read result valid |
| rd_count | output | CNT_W | Counter value read |
| rd_offset | output | ADDR_W | Window offset read |
| rd_ovf | output | 1 | Overflow flag read |
| any_pending | output | 1 | Some counter is non-zero |

## Verification
A wrong offset or base shows on `mem_addr` at the very next payload flit to that tag. A wrong window bound shows as a missing or extra `mem_we` one cycle after a flit arrives at the window edge. Counter faults do not appear on `mem_*`. They show on `any_pending` one cycle after the change, or on `rd_count` at the next peek or load-and-clear. The bench therefore places a read after every scenario, and checks the pending output and the memory port against its own model on every clock.

// File: rtl/noc_rx_tag_window.sv
module noc_rx_tag_window #(
  parameter int NUM_TAGS = 256,
  parameter int ADDR_W   = 16,
  parameter int CNT_W    = 16,
  parameter int FLIT_W   = 32,
  localparam int TAG_W   = $clog2(NUM_TAGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flit_valid,
  input  logic [TAG_W-1:0]  flit_tag,
  input  logic [1:0]        flit_cmd,
  input  logic [FLIT_W-1:0] flit_data,
  input  logic [1:0]        reg_op,
  input  logic [TAG_W-1:0]  reg_tag,
  input  logic [ADDR_W-1:0] reg_base,
  input  logic [ADDR_W-1:0] reg_size,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [FLIT_W-1:0] mem_wdata,
  output logic              rd_valid,
  output logic [CNT_W-1:0]  rd_count,
  output logic [ADDR_W-1:0] rd_offset,
  output logic              rd_ovf,
  output logic              any_pending
);
  localparam logic [1:0] CMD_PAY = 2'd0, CMD_EOT = 2'd1;
  localparam logic [1:0] OP_CFG = 2'd1, OP_LC = 2'd3;

  logic [ADDR_W-1:0] base_q [NUM_TAGS];
  logic [ADDR_W-1:0] size_q [NUM_TAGS];
  logic [ADDR_W-1:0] off_q  [NUM_TAGS];
  logic [CNT_W-1:0]  cnt_q  [NUM_TAGS];
  logic [NUM_TAGS-1:0] ovf_q;

  wire is_pay  = flit_valid && flit_cmd == CMD_PAY;
  wire is_eot  = flit_valid && flit_cmd == CMD_EOT;
  wire in_win  = off_q[flit_tag] < size_q[flit_tag];
  wire eot_hit = is_eot && flit_tag == reg_tag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_TAGS; i++) begin
        base_q[i] <= '0;
        size_q[i] <= '0;
        off_q[i]  <= '0;
        cnt_q[i]  <= '0;
      end
      ovf_q     <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      rd_valid  <= 1'b0;
      rd_count  <= '0;
      rd_offset <= '0;
      rd_ovf    <= 1'b0;
    end else begin
      mem_we   <= 1'b0;
      rd_valid <= 1'b0;
      if (is_pay) begin
        if (in_win) begin
          mem_we          <= 1'b1;
          mem_addr        <= base_q[flit_tag] + off_q[flit_tag];
          mem_wdata       <= flit_data;
          off_q[flit_tag] <= off_q[flit_tag] + ADDR_W'(1);
        end else begin
          ovf_q[flit_tag] <= 1'b1;
        end
      end
      if (is_eot && cnt_q[flit_tag] != '1)
        cnt_q[flit_tag] <= cnt_q[flit_tag] + CNT_W'(1);
      if (reg_op[1]) begin
        rd_valid  <= 1'b1;
        rd_count  <= cnt_q[reg_tag];
        rd_offset <= off_q[reg_tag];
        rd_ovf    <= ovf_q[reg_tag];
      end
      if (reg_op == OP_LC)
        cnt_q[reg_tag] <= eot_hit ? CNT_W'(1) : '0;
      if (reg_op == OP_CFG) begin
        base_q[reg_tag] <= reg_base;
        size_q[reg_tag] <= reg_size;
        off_q[reg_tag]  <= '0;
        ovf_q[reg_tag]  <= 1'b0;
      end
    end
  end

  always_comb begin
    any_pending = 1'b0;
    for (int i = 0; i < NUM_TAGS; i++)
      any_pending = any_pending | (cnt_q[i] != '0);
  end

  AST_WRITE_NEEDS_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(is_pay)); // R2
  AST_READ_NEEDS_OP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(reg_op[1])); // R9
  AST_PENDING_NEEDS_EOT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(any_pending) |-> $past(is_eot)); // R8
  AST_OVF_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pay && ovf_q[flit_tag] && !(reg_op == OP_CFG && reg_tag == flit_tag)) |=> !mem_we); // R3
  AST_COUNT_HOLDS_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    (is_eot && cnt_q[flit_tag] == '1 && !(reg_op == OP_LC && reg_tag == flit_tag))
      |=> cnt_q[$past(flit_tag)] == '1); // R7
endmodule

// File: tb/noc_rx_tag_window_tb.sv
module noc_rx_tag_window_tb_top;
  localparam int NT = 256, AW = 16, CW = 16, FW = 32, TW = 8;
  logic clk = 0, rst_n = 0;
  logic fv = 0; logic [TW-1:0] ft = 0; logic [1:0] fc = 0; logic [FW-1:0] fd = 0;
  logic [1:0] op = 0; logic [TW-1:0] rt = 0; logic [AW-1:0] rb = 0, rs = 0;
  logic mem_we, rd_valid, rd_ovf, any_pending;
  logic [AW-1:0] mem_addr, rd_offset; logic [FW-1:0] mem_wdata; logic [CW-1:0] rd_count;
  int tests = 0, fails = 0, cycles = 0;

  noc_rx_tag_window dut_i (.clk(clk), .rst_n(rst_n), .flit_valid(fv), .flit_tag(ft),
    .flit_cmd(fc), .flit_data(fd), .reg_op(op), .reg_tag(rt), .reg_base(rb), .reg_size(rs),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .rd_valid(rd_valid),
    .rd_count(rd_count), .rd_offset(rd_offset), .rd_ovf(rd_ovf), .any_pending(any_pending));

  always #10 clk = ~clk;

  int m_base[NT], m_size[NT], m_off[NT], m_cnt[NT]; bit m_ovf[NT];
  bit e_we, e_rv, e_ovf, e_pend; int e_addr, e_rc, e_ro; logic [FW-1:0] e_data;

  always @(posedge clk) begin
    int oc, oo; bit ov;
    cycles++;
    if (!rst_n) begin
      for (int i = 0; i < NT; i++) begin m_base[i]=0; m_size[i]=0; m_off[i]=0; m_cnt[i]=0; m_ovf[i]=0; end
      e_we=0; e_rv=0; e_pend=0;
    end else begin
      oc = m_cnt[rt]; oo = m_off[rt]; ov = m_ovf[rt];
      e_we = 0; e_rv = 0;
      if (fv && fc == 0) begin
        if (m_off[ft] < m_size[ft]) begin
          e_we = 1; e_addr = (m_base[ft] + m_off[ft]) % 65536; e_data = fd; m_off[ft]++;
        end else m_ovf[ft] = 1;
      end
      if (fv && fc == 1 && m_cnt[ft] < 65535) m_cnt[ft]++;
      if (op >= 2) begin e_rv = 1; e_rc = oc; e_ro = oo; e_ovf = ov; end
      if (op == 3) m_cnt[rt] = (fv && fc == 1 && ft == rt) ? 1 : 0;
      if (op == 1) begin m_base[rt]=rb; m_size[rt]=rs; m_off[rt]=0; m_ovf[rt]=0; end
      e_pend = 0;
      for (int i = 0; i < NT; i++) if (m_cnt[i] != 0) e_pend = 1;
    end
  end

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin fails++; $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time); end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R2 mem_we", mem_we, e_we);
    if (e_we) begin chk("R2 mem_addr", mem_addr, e_addr); chk("R2 mem_wdata", mem_wdata, e_data); end
    chk("R9 rd_valid", rd_valid, e_rv);
    if (e_rv) begin chk("R6 rd_count", rd_count, e_rc); chk("R9 rd_offset", rd_offset, e_ro); chk("R3 rd_ovf", rd_ovf, e_ovf); end
    chk("R8 any_pending", any_pending, e_pend);
  end

  task automatic cyc(bit v, int t, int c, int d, int o, int tg, int b, int s);
    fv = v; ft = TW'(t); fc = 2'(c); fd = FW'(d); op = 2'(o); rt = TW'(tg); rb = AW'(b); rs = AW'(s);
    @(negedge clk);
    fv = 0; op = 0;
  endtask

  task automatic peek(int t, int c, int o, bit v, string req);
    cyc(0, 0, 0, 0, 2, t, 0, 0);
    chk({req, " peek count"}, rd_count, c);
    chk({req, " peek offset"}, rd_offset, o);
    chk({req, " peek ovf"}, rd_ovf, v);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 mem_we", mem_we, 0); chk("R1 rd_valid", rd_valid, 0); chk("R1 any_pending", any_pending, 0);
    rst_n = 1; @(negedge clk);
    peek(5, 0, 0, 0, "R1");
    cyc(1, 7, 0, 32'h11, 0, 0, 0, 0);
    chk("R1 zero window drops", mem_we, 0);
    peek(7, 0, 0, 1, "R1");
    cyc(0, 0, 0, 0, 1, 3, 16'h100, 4);
    for (int i = 0; i < 6; i++) cyc(1, 3, 0, 32'hA0 + i, 0, 0, 0, 0);
    chk("R3 dropped beyond window", mem_we, 0);
    peek(3, 0, 4, 1, "R3");
    cyc(0, 0, 0, 0, 1, 200, 16'hFFFE, 4);
    for (int i = 0; i < 4; i++) begin
      cyc(1, 200, 0, 32'hB0 + i, 0, 0, 0, 0);
      chk("R2 wrap addr", mem_addr, (16'hFFFE + i) % 65536);
    end
    cyc(1, 200, 2, 1, 0, 0, 0, 0); cyc(1, 200, 3, 1, 0, 0, 0, 0);
    peek(200, 0, 4, 0, "R5 ignored cmds");
    for (int i = 0; i < 3; i++) cyc(1, 3, 1, 0, 0, 0, 0, 0);
    chk("R8 pending after eot", any_pending, 1);
    peek(3, 3, 4, 1, "R5");
    cyc(0, 0, 0, 0, 3, 3, 0, 0);
    chk("R6 lc returns old", rd_count, 3);
    chk("R8 pending cleared", any_pending, 0);
    peek(3, 0, 4, 1, "R6");
    cyc(1, 3, 1, 0, 0, 0, 0, 0); cyc(1, 3, 1, 0, 0, 0, 0, 0);
    cyc(1, 3, 1, 0, 3, 3, 0, 0);
    chk("R6 collide returns old", rd_count, 2);
    peek(3, 1, 4, 1, "R6 collide leaves 1");
    cyc(1, 3, 0, 32'hCC, 1, 3, 16'h40, 2);
    peek(3, 1, 0, 0, "R4");
    cyc(1, 3, 0, 32'hDD, 0, 0, 0, 0);
    chk("R4 new base", mem_addr, 16'h40);
    for (int i = 0; i < 65540; i++) cyc(1, 9, 1, 0, 0, 0, 0, 0);
    peek(9, 65535, 0, 0, "R7");
    cyc(0, 0, 0, 0, 3, 9, 0, 0);
    chk("R7 lc at max", rd_count, 65535);
    cyc(0, 0, 0, 0, 3, 3, 0, 0);
    chk("R8 all clear", any_pending, 0);
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cycles > 190000);
    fails++; tests++;
    $display("FAIL watchdog actual=%0d expected=<190000 cycles", cycles);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule